// File: doc/BRIEF.md
# Memory-Zone Layout String Decoder

This block decodes a short ASCII text that describes one contiguous memory zone. Characters arrive one per clock on a byte input with a qualifying strobe, and a separate strobe marks the end of the text. The text opens with a hash mark and a slash. It then gives the zone base address in hexadecimal with a `0x` prefix, a slash, a decimal sector count, an asterisk, and a decimal sector size. A unit letter scales the size, and a final letter carries the access rights as a three-bit code.

When the end strobe arrives after a complete, well-formed text, the decoder pulses a valid flag. At that point it presents the base address, the sector count, the size of one sector in bytes, the zone size in bytes, and three access flags. Any syntax fault, an over-long number, or an early end pulses an error flag instead. The decoder then waits for the next text. Digit limits count only significant digits, so zero padding such as `064` or `0002` is accepted.

Top module: `zone_desc_decoder`

## Requirements
- R1: A text must open with `#`, then `/`, then `0`, then `x` or `X`. Any other character in these positions makes the text erroneous.
- R2: The address field holds 1 to 8 significant hexadecimal digits in either letter case and ends with `/`. Leading zeros are not counted toward the limit, and a ninth significant digit is an error.
- R3: The sector count holds 1 to 2 significant decimal digits (value 0 to 99) and ends with `*`.
- R4: The sector size holds 1 to 3 significant decimal digits (0 to 999) and ends with an upper-case unit letter: `B` scales by 1, `K` by 1024 and `M` by 1048576.
- R5: The type letter is `a`..`g` or `A`..`G`. Its code is the letter's low three bits (1 to 7): bit 0 gives readable, bit 1 gives erasable and bit 2 gives writeable.
- R6: Sector bytes equal size times unit. Zone bytes equal sector count times sector bytes, kept modulo 2^32.
- R7: `valid_o` is high for exactly one cycle, in the cycle after the end strobe of a well-formed text. The decoded outputs then hold until the next `#` starts a text.
- R8: `err_o` is high for exactly one cycle after the end strobe, and `valid_o` stays low, if any of these occurred: an unexpected character, an exceeded digit limit, an empty number field, an end before the type letter, or any character after the type letter. Characters after the first fault are ignored.
- R9: A character and the end strobe in the same cycle are handled with the character consumed first.
- R10: Each end strobe returns the decoder to its start state, so a following text decodes independently of an earlier faulty one.
- R11: The text `#/0x08000000/064*0002Kg` decodes to address 0x08000000, 64 sectors of 2048 bytes, zone bytes 131072, and all three access flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_i | input | 8 | ASCII character |
| chr_vld_i | input | 1 | Character strobe |
| eos_i | input | 1 | End-of-text strobe |
| zone_addr_o | output | 32 | Decoded base address |
| sect_cnt_o | output | 7 | Decoded sector count |
| sect_bytes_o | output | 32 | Bytes per sector |
| zone_bytes_o | output | 32 | Bytes in the zone (mod 2^32) |
| rd_o | output | 1 | Readable flag |
| er_o | output | 1 | Erasable flag |
| wr_o | output | 1 | Writeable flag |
| valid_o | output | 1 | One-cycle well-formed result pulse |
| err_o | output | 1 | One-cycle malformed text pulse |

## Verification
The hardest condition to reach is the digit limit, because leading zeros must pass while the first surplus significant digit must fail. The stimulus therefore pads fields with long zero runs just under and just over each limit. Complete sweeps of the sector count (0..99), the sector size (0..999), all three units at the largest values, and all seven type letters in both cases check the byte arithmetic, including the 32-bit wrap. Faults are injected at every field position, and each faulty text is followed by a good one to show recovery.

// File: rtl/zdd_pkg.sv
package zdd_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_SLASH, ST_ZERO, ST_X, ST_ADDR,
      ST_CNT, ST_SIZE, ST_TYPE, ST_TAIL, ST_FAULT
   } zdd_state_e;

   typedef enum logic [1:0] {
      UNIT_BYTE = 2'd0,
      UNIT_KIB  = 2'd1,
      UNIT_MIB  = 2'd2
   } zdd_unit_e;
endpackage

// File: rtl/zdd_char_class.sv
module zdd_char_class
   import zdd_pkg::*;
(
   input  logic [7:0] chr_i,
   output logic       is_dec_o,
   output logic       is_hex_o,
   output logic [3:0] nib_o,
   output logic       is_unit_o,
   output zdd_unit_e  unit_o,
   output logic       is_type_o,
   output logic [2:0] type_o
);
   logic [7:0] upper;

   always_comb begin
      upper     = chr_i & 8'hDF;
      is_dec_o  = (chr_i >= 8'h30) && (chr_i <= 8'h39);
      is_hex_o  = is_dec_o || ((upper >= 8'h41) && (upper <= 8'h46));
      nib_o     = is_dec_o ? chr_i[3:0] : 4'(chr_i[3:0] + 4'd9);
      is_unit_o = (chr_i == 8'h42) || (chr_i == 8'h4B) || (chr_i == 8'h4D);
      unit_o    = (chr_i == 8'h4B) ? UNIT_KIB :
                  (chr_i == 8'h4D) ? UNIT_MIB : UNIT_BYTE;
      is_type_o = (upper >= 8'h41) && (upper <= 8'h47);
      type_o    = upper[2:0];
   end
endmodule

// File: rtl/zdd_num_field.sv
module zdd_num_field #(
   parameter bit IS_HEX     = 1'b0,
   parameter int MAX_DIGITS = 3,
   parameter int W          = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         dig_i,
   input  logic [3:0]   nib_i,
   output logic [W-1:0] val_o,
   output logic         seen_o,
   output logic         ovf_o
);
   localparam int SW = $clog2(MAX_DIGITS + 1);

   logic [W-1:0]  val_q, val_nxt;
   logic [SW-1:0] sig_q;
   logic          lead;

   generate
      if (MAX_DIGITS < 1) begin : g_bad_digits
         $error("zdd_num_field: MAX_DIGITS must be at least 1");
      end
      if (IS_HEX) begin : g_hex
         if (W != 4 * MAX_DIGITS) begin : g_bad_w
            $error("zdd_num_field: hex width must be 4 per digit");
         end
         always_comb val_nxt = W'({val_q, nib_i});
      end else begin : g_dec
         always_comb val_nxt = W'(val_q * W'(10)) + W'(nib_i);
      end
   endgenerate

   assign lead  = (sig_q == '0) && (nib_i == 4'd0);
   assign ovf_o = dig_i && !lead && (sig_q == SW'(MAX_DIGITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         sig_q  <= '0;
         seen_o <= 1'b0;
      end else if (clr_i) begin
         val_q  <= '0;
         sig_q  <= '0;
         seen_o <= 1'b0;
      end else if (dig_i && !ovf_o) begin
         val_q  <= val_nxt;
         seen_o <= 1'b1;
         if (!lead) sig_q <= sig_q + SW'(1);
      end
   end

   assign val_o = val_q;

   // R2 R3 R4
   sig_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sig_q <= SW'(MAX_DIGITS));

   // R2 R3 R4
   digit_marks_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_i && !ovf_o && !clr_i) |=> seen_o);
endmodule

// File: rtl/zdd_size_calc.sv
module zdd_size_calc
   import zdd_pkg::*;
#(
   parameter int CW  = 7,
   parameter int SZW = 10
) (
   input  logic [CW-1:0]  cnt_i,
   input  logic [SZW-1:0] size_i,
   input  zdd_unit_e      unit_i,
   output logic [31:0]    sect_bytes_o,
   output logic [31:0]    zone_bytes_o
);
   generate
      if (SZW + 20 > 32 || CW > 32) begin : g_bad_width
         $error("zdd_size_calc: scaled sector size exceeds 32 bits");
      end
   endgenerate

   always_comb begin
      case (unit_i)
         UNIT_KIB: sect_bytes_o = 32'(size_i) << 10;
         UNIT_MIB: sect_bytes_o = 32'(size_i) << 20;
         default:  sect_bytes_o = 32'(size_i);
      endcase
      zone_bytes_o = sect_bytes_o * 32'(cnt_i);
   end
endmodule

// File: rtl/zone_desc_decoder.sv
module zone_desc_decoder
   import zdd_pkg::*;
#(
   parameter int ADDR_DIGITS = 8,
   parameter int CNT_DIGITS  = 2,
   parameter int SIZE_DIGITS = 3,
   localparam int AW  = 4 * ADDR_DIGITS,
   localparam int CW  = $clog2(10 ** CNT_DIGITS),
   localparam int SZW = $clog2(10 ** SIZE_DIGITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    chr_i,
   input  logic          chr_vld_i,
   input  logic          eos_i,
   output logic [AW-1:0] zone_addr_o,
   output logic [CW-1:0] sect_cnt_o,
   output logic [31:0]   sect_bytes_o,
   output logic [31:0]   zone_bytes_o,
   output logic          rd_o,
   output logic          er_o,
   output logic          wr_o,
   output logic          valid_o,
   output logic          err_o
);
   generate
      if (AW > 32) begin : g_bad_addr
         $error("zone_desc_decoder: address wider than 32 bits");
      end
   endgenerate

   zdd_state_e  st_q, st_n;
   zdd_unit_e   unit_q, unit_c;
   logic [2:0]  type_q, type_c;
   logic        is_dec, is_hex, is_unit, is_type;
   logic [3:0]  nib;
   logic        clr, a_dig, c_dig, s_dig, unit_ld, type_ld, fin_ok;
   logic        a_seen, c_seen, s_seen, a_ovf, c_ovf, s_ovf;
   logic [SZW-1:0] size_val;

   zdd_char_class i_class (
      .chr_i(chr_i), .is_dec_o(is_dec), .is_hex_o(is_hex), .nib_o(nib),
      .is_unit_o(is_unit), .unit_o(unit_c), .is_type_o(is_type), .type_o(type_c));

   zdd_num_field #(.IS_HEX(1'b1), .MAX_DIGITS(ADDR_DIGITS), .W(AW)) i_addr (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .dig_i(a_dig), .nib_i(nib),
      .val_o(zone_addr_o), .seen_o(a_seen), .ovf_o(a_ovf));

   zdd_num_field #(.IS_HEX(1'b0), .MAX_DIGITS(CNT_DIGITS), .W(CW)) i_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .dig_i(c_dig), .nib_i(nib),
      .val_o(sect_cnt_o), .seen_o(c_seen), .ovf_o(c_ovf));

   zdd_num_field #(.IS_HEX(1'b0), .MAX_DIGITS(SIZE_DIGITS), .W(SZW)) i_size (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .dig_i(s_dig), .nib_i(nib),
      .val_o(size_val), .seen_o(s_seen), .ovf_o(s_ovf));

   zdd_size_calc #(.CW(CW), .SZW(SZW)) i_calc (
      .cnt_i(sect_cnt_o), .size_i(size_val), .unit_i(unit_q),
      .sect_bytes_o(sect_bytes_o), .zone_bytes_o(zone_bytes_o));

   always_comb begin
      st_n    = st_q;
      clr     = 1'b0;
      a_dig   = 1'b0;
      c_dig   = 1'b0;
      s_dig   = 1'b0;
      unit_ld = 1'b0;
      type_ld = 1'b0;
      if (chr_vld_i) begin
         case (st_q)
            ST_IDLE:  if (chr_i == 8'h23) begin st_n = ST_SLASH; clr = 1'b1; end
                      else st_n = ST_FAULT;
            ST_SLASH: st_n = (chr_i == 8'h2F) ? ST_ZERO : ST_FAULT;
            ST_ZERO:  st_n = (chr_i == 8'h30) ? ST_X : ST_FAULT;
            ST_X:     st_n = ((chr_i & 8'hDF) == 8'h58) ? ST_ADDR : ST_FAULT;
            ST_ADDR:  if (is_hex) begin
                         a_dig = 1'b1;
                         if (a_ovf) st_n = ST_FAULT;
                      end else if (chr_i == 8'h2F && a_seen) st_n = ST_CNT;
                      else st_n = ST_FAULT;
            ST_CNT:   if (is_dec) begin
                         c_dig = 1'b1;
                         if (c_ovf) st_n = ST_FAULT;
                      end else if (chr_i == 8'h2A && c_seen) st_n = ST_SIZE;
                      else st_n = ST_FAULT;
            ST_SIZE:  if (is_dec) begin
                         s_dig = 1'b1;
                         if (s_ovf) st_n = ST_FAULT;
                      end else if (is_unit && s_seen) begin
                         unit_ld = 1'b1;
                         st_n    = ST_TYPE;
                      end else st_n = ST_FAULT;
            ST_TYPE:  if (is_type) begin type_ld = 1'b1; st_n = ST_TAIL; end
                      else st_n = ST_FAULT;
            default:  st_n = ST_FAULT;
         endcase
      end
      fin_ok = (st_n == ST_TAIL);
      if (eos_i) st_n = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         unit_q  <= UNIT_BYTE;
         type_q  <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         st_q    <= st_n;
         valid_o <= eos_i && fin_ok;
         err_o   <= eos_i && !fin_ok;
         if (clr)     begin unit_q <= UNIT_BYTE; type_q <= '0; end
         if (unit_ld) unit_q <= unit_c;
         if (type_ld) type_q <= type_c;
      end
   end

   assign rd_o = type_q[0];
   assign er_o = type_q[1];
   assign wr_o = type_q[2];

   // R7
   valid_after_eos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(eos_i));

   // R8
   err_after_eos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(eos_i));

   // R8
   valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && err_o));

   // R7
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R5
   valid_has_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (rd_o || er_o || wr_o));

   // R10
   eos_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eos_i |=> (st_q == ST_IDLE));
endmodule

// File: tb/test_zone_desc_decoder.sv
module test_zone_desc_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  chr = '0;
   logic        cv = 1'b0;
   logic        eos = 1'b0;
   logic [31:0] zaddr, sbytes, zbytes;
   logic [6:0]  scnt;
   logic        rd, er, wr, vld, err;

   int checks = 0;
   int fails  = 0;
   logic got_v, got_e, after_v;

   always #10 clk = ~clk;

   zone_desc_decoder i_zone_desc_decoder (
      .clk(clk), .rst_n(rst_n), .chr_i(chr), .chr_vld_i(cv), .eos_i(eos),
      .zone_addr_o(zaddr), .sect_cnt_o(scnt), .sect_bytes_o(sbytes),
      .zone_bytes_o(zbytes), .rd_o(rd), .er_o(er), .wr_o(wr),
      .valid_o(vld), .err_o(err));

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run(input string s, input bit merge);
      for (int i = 0; i < s.len(); i++) begin
         @(negedge clk);
         chr = s[i];
         cv  = 1'b1;
         eos = merge && (i == s.len() - 1);
      end
      if (!merge || s.len() == 0) begin
         @(negedge clk);
         cv = 1'b0; chr = '0; eos = 1'b1;
      end
      @(negedge clk);
      cv = 1'b0; eos = 1'b0;
      got_v = vld; got_e = err;
      @(negedge clk);
      after_v = vld || err;
   endtask

   task automatic expect_ok(input string tag, input longint a, input longint c,
                            input longint sb, input longint t, input int ty);
      chk({tag, " valid"}, got_v, 1);
      chk({tag, " err"}, got_e, 0);
      chk({tag, " pulse"}, after_v, 0);
      chk({tag, " addr"}, zaddr, a);
      chk({tag, " count"}, scnt, c);
      chk({tag, " sector"}, sbytes, sb);
      chk({tag, " zone"}, zbytes, t & 64'hFFFF_FFFF);
      chk({tag, " rights"}, {wr, er, rd}, ty);
   endtask

   task automatic expect_err(input string tag);
      chk({tag, " err"}, got_e, 1);
      chk({tag, " valid"}, got_v, 0);
      chk({tag, " pulse"}, after_v, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk("R7 reset valid", vld, 0);
      chk("R8 reset err", err, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 worked example
      run("#/0x08000000/064*0002Kg", 1'b0);
      expect_ok("R11", 32'h0800_0000, 64, 2048, 131072, 7);

      // R9 last char together with end strobe
      run("#/0x1/2*3Kb", 1'b1);
      expect_ok("R9", 1, 2, 3072, 6144, 2);

      // R2 mixed-case hex, full width, zero padding
      run("#/0XdEaDbEeF/1*1Ba", 1'b0);
      expect_ok("R2 case", 32'hDEAD_BEEF, 1, 1, 1, 1);
      run("#/0x000012345678/1*1Ba", 1'b0);
      expect_ok("R2 pad", 32'h1234_5678, 1, 1, 1, 1);
      run("#/0x123456789/1*1Ba", 1'b0);
      expect_err("R2 nine digits");
      run("#/0x/1*1Ba", 1'b0);
      expect_err("R2 empty");

      // R3 count sweep
      for (int n = 0; n < 100; n++) begin
         run($sformatf("#/0x4/%0d*1Kg", n), 1'b0);
         expect_ok("R3 sweep", 4, n, 1024, n * 1024, 7);
      end
      run("#/0x4/00099*1Kg", 1'b0);
      expect_ok("R3 pad", 4, 99, 1024, 99 * 1024, 7);
      run("#/0x4/100*1Kg", 1'b0);
      expect_err("R3 three digits");
      run("#/0x4/*1Kg", 1'b0);
      expect_err("R3 empty");

      // R4 size sweep
      for (int z = 0; z < 1000; z++) begin
         run($sformatf("#/0x8/3*%0dBe", z), 1'b0);
         expect_ok("R4 sweep", 8, 3, z, 3 * z, 5);
      end
      run("#/0x8/3*0000999Be", 1'b0);
      expect_ok("R4 pad", 8, 3, 999, 2997, 5);
      run("#/0x8/3*1000Be", 1'b0);
      expect_err("R4 four digits");
      run("#/0x8/3*5kg", 1'b0);
      expect_err("R4 lower unit");

      // R6 unit scaling and 32-bit wrap
      run("#/0x0/99*999Bc", 1'b0);
      expect_ok("R6 B", 0, 99, 999, 99 * 999, 3);
      run("#/0x0/99*999Kc", 1'b0);
      expect_ok("R6 K", 0, 99, 999 * 1024, 99 * 999 * 1024, 3);
      run("#/0x0/99*999Mc", 1'b0);
      expect_ok("R6 M", 0, 99, 999 * 1048576, 99 * 999 * 1048576, 3);

      // R5 all type letters in both cases
      for (int t = 1; t < 8; t++) begin
         string s;
         s = "#/0x2/1*1B";
         run({s, string'(8'h60 + t)}, 1'b0);
         expect_ok("R5 lower", 2, 1, 1, 1, t);
         run({s, string'(8'h40 + t)}, 1'b0);
         expect_ok("R5 upper", 2, 1, 1, 1, t);
      end
      run("#/0x2/1*1Bh", 1'b0);
      expect_err("R5 letter h");

      // R1 header faults
      run("/0x2/1*1Bg", 1'b0);
      expect_err("R1 no hash");
      run("#0x2/1*1Bg", 1'b0);
      expect_err("R1 no slash");
      run("#/1x2/1*1Bg", 1'b0);
      expect_err("R1 bad zero");
      run("#/0y2/1*1Bg", 1'b0);
      expect_err("R1 bad x");

      // R8 early end, trailing char, empty text, garbage then end
      run("#/0x10/2*3K", 1'b0);
      expect_err("R8 early end");
      run("#/0x10/2*3Kgg", 1'b0);
      expect_err("R8 trailing");
      run("", 1'b0);
      expect_err("R8 empty");
      run("#/0x1q/2*3Kg", 1'b0);
      expect_err("R8 bad char");

      // R10 recovery after fault
      run("#/0xAB/7*5Md", 1'b0);
      expect_ok("R10 recover", 32'hAB, 7, 5 * 1048576, 35 * 1048576, 4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule